// File: doc/BRIEF.md
# Write Precompensation Shifter

This block sits on the write path of a floppy-style disk controller. It receives the serial MFM cell stream one bit per bit-cell strobe and emits one single-clock write pulse for every 1 cell. A fast sample clock divides each bit cell into eight sub-steps. The pulse lands on the middle sub-step, or is moved earlier or later by a programmable number of sub-steps. The choice depends on where the nearest neighbouring transitions sit. Bit shift on the medium pushes crowded transitions apart, and this pre-distortion puts them back near their nominal spacing.

Two configuration registers set the behaviour. One holds the shift magnitude in sub-steps and comes out of reset at a default value. The other holds the first track on which shifting is allowed and comes out of reset at track zero. The current track number is an input. On any track below the programmed start, every pulse is written at the nominal sub-step.

Top module: `wprecomp_shifter`

## Requirements
- R1: After reset the shift magnitude is 2 sub-steps and the starting track is 0, so shifting is active on every track.
- R2: The decision window holds five cells in time order: before-2, before-1, centre, after-1, after-2. A centre cell of 0 produces no pulse. A centre 1 is shifted late when before-2 is 1 and after-2 is 0. It is shifted early when before-2 is 0 and after-2 is 1. In every other case it stays at the nominal position.
- R3: A pulse is high for the clock period that begins k rising edges after the edge that sampled the strobe of its output cell. k is 4 for nominal, 4 minus the magnitude for early, and 4 plus the magnitude for late.
- R4: The bit sampled with strobe n becomes the window centre at strobe n+2, and its pulse is emitted within the cell that starts at strobe n+2.
- R5: A write to the magnitude register stores the written value, but any value above 3 is stored as 3.
- R6: A write to the start-track register takes effect for later cells. While the current track is below the start track, every pulse is emitted at k = 4.
- R7: When the current track equals or exceeds the start track, the shifts of R2 and R3 apply.
- R8: With a magnitude of 0, the pulse train equals the input cell stream delayed by two cells plus four sub-steps.
- R9: Each pulse lasts exactly one clock, and each 1 cell produces exactly one pulse.
- R10: During reset and until a 1 cell reaches the window centre, wrPulse stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-step sample clock, eight periods per bit cell |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-clock strobe marking the start of each bit cell |
| bitIn | input | 1 | MFM cell value, sampled when bitStrobe is high |
| curTrack | input | 8 | Track currently being written |
| cfgShiftWe | input | 1 | Write enable for the shift magnitude register |
| cfgShiftData | input | 3 | New shift magnitude in sub-steps |
| cfgTrackWe | input | 1 | Write enable for the start-track register |
| cfgTrackData | input | 8 | New starting track |
| wrPulse | output | 1 | Precompensated write pulse |

## Verification
Several cell patterns are sent, and the exact clock edge of every pulse is compared against an independent model of the window rule. A design that mirrored the window, or swapped the early and late cases, would put pulses on the wrong sub-step. The track gate is tested one below, exactly at, and well above the start track, which exposes an off-by-one compare. The bench also writes a magnitude above the limit and a magnitude of zero. A missing clamp would push pulses outside the cell, and a zero-magnitude bug would show up as jitter on a plain delayed stream.

// File: rtl/precomp_pkg.sv
package precomp_pkg;

  localparam int SUB_STEPS   = 8;
  localparam int STEP_W      = $clog2(SUB_STEPS);
  localparam int NOMINAL_TAP = SUB_STEPS / 2;
  localparam int MAX_SHIFT   = NOMINAL_TAP - 1;
  localparam int WIN_LEN     = 5;
  localparam int POS_BEFORE2 = WIN_LEN - 1;
  localparam int POS_CENTRE  = WIN_LEN / 2;
  localparam int POS_AFTER2  = 0;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_EARLY = 2'd1,
    SHIFT_LATE  = 2'd2
  } shift_dir_e;

  // Strobes and settings handed from control to datapath each clock.
  typedef struct packed {
    logic              shiftIn;
    logic              gateOn;
    logic [STEP_W-1:0] amount;
    logic [STEP_W-1:0] step;
  } precomp_strobe_t;

  // Move a transition away from its closest neighbour (two cells away).
  function automatic shift_dir_e classifyWindow(input logic [WIN_LEN-1:0] win);
    if (!win[POS_CENTRE]) return SHIFT_NONE;
    if (win[POS_BEFORE2] && !win[POS_AFTER2]) return SHIFT_LATE;
    if (!win[POS_BEFORE2] && win[POS_AFTER2]) return SHIFT_EARLY;
    return SHIFT_NONE;
  endfunction

endpackage

// File: rtl/precomp_ctrl.sv
module precomp_ctrl
  import precomp_pkg::*;
#(
  parameter int TRACK_W       = 8,
  parameter int DEFAULT_SHIFT = 2,
  parameter int DEFAULT_START = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitStrobe,
  input  logic [TRACK_W-1:0]    curTrack,
  input  logic                  cfgShiftWe,
  input  logic [STEP_W-1:0]     cfgShiftData,
  input  logic                  cfgTrackWe,
  input  logic [TRACK_W-1:0]    cfgTrackData,
  output precomp_strobe_t       strb
);

  localparam logic [STEP_W-1:0]  SHIFT_LIMIT = STEP_W'(MAX_SHIFT);
  localparam logic [STEP_W-1:0]  SHIFT_RESET = STEP_W'(DEFAULT_SHIFT);
  localparam logic [TRACK_W-1:0] START_RESET = TRACK_W'(DEFAULT_START);
  localparam logic [STEP_W-1:0]  LAST_STEP   = STEP_W'(SUB_STEPS - 1);

  logic [STEP_W-1:0]  shiftAmt;
  logic [TRACK_W-1:0] startTrack;
  logic [STEP_W-1:0]  stepCnt;
  logic [STEP_W-1:0]  shiftClamped;

  always_comb begin
    shiftClamped = (cfgShiftData > SHIFT_LIMIT) ? SHIFT_LIMIT : cfgShiftData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftAmt   <= SHIFT_RESET;
      startTrack <= START_RESET;
    end else begin
      if (cfgShiftWe) shiftAmt   <= shiftClamped;
      if (cfgTrackWe) startTrack <= cfgTrackData;
    end
  end

  // Sub-step position within the current cell; holds at the last step
  // if the next strobe is late.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= LAST_STEP;
    end else if (bitStrobe) begin
      stepCnt <= '0;
    end else if (stepCnt != LAST_STEP) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    strb.shiftIn = bitStrobe;
    strb.gateOn  = (curTrack >= startTrack);
    strb.amount  = shiftAmt;
    strb.step    = stepCnt;
  end

  AST_AMT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    shiftAmt <= SHIFT_LIMIT); // R5

  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> (stepCnt == '0)); // R3

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgTrackWe |=> (startTrack == $past(cfgTrackData))); // R6

endmodule

// File: rtl/precomp_datapath.sv
module precomp_datapath
  import precomp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  precomp_strobe_t strb,
  input  logic            bitIn,
  output logic            wrPulse
);

  localparam logic [STEP_W-1:0] NOM     = STEP_W'(NOMINAL_TAP);
  localparam logic [STEP_W-1:0] TAP_MIN = STEP_W'(NOMINAL_TAP - MAX_SHIFT);
  localparam logic [STEP_W-1:0] TAP_MAX = STEP_W'(NOMINAL_TAP + MAX_SHIFT);

  logic [WIN_LEN-1:0] window;
  logic [WIN_LEN-1:0] nextWindow;
  shift_dir_e         dir;
  logic [STEP_W-1:0]  tapCalc;
  logic               pendValid;
  logic [STEP_W-1:0]  pendTap;
  logic               fire;

  always_comb begin
    nextWindow = {window[WIN_LEN-2:0], bitIn};
    dir        = classifyWindow(nextWindow);
    tapCalc    = NOM;
    if (strb.gateOn) begin
      case (dir)
        SHIFT_EARLY: tapCalc = NOM - strb.amount;
        SHIFT_LATE:  tapCalc = NOM + strb.amount;
        default:     tapCalc = NOM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window <= '0;
    end else if (strb.shiftIn) begin
      window <= nextWindow;
    end
  end

  always_comb begin
    fire = pendValid && (strb.step == pendTap);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendTap   <= NOM;
    end else if (strb.shiftIn) begin
      pendValid <= nextWindow[POS_CENTRE];
      pendTap   <= tapCalc;
    end else if (fire) begin
      pendValid <= 1'b0;
    end
  end

  assign wrPulse = fire;

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse); // R9

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> (strb.step >= TAP_MIN && strb.step <= TAP_MAX)); // R3

  AST_GATE_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftIn && !strb.gateOn) |=> (pendTap == NOM)); // R6

  AST_ZERO_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftIn && strb.amount == '0) |=> (pendTap == NOM)); // R8

endmodule

// File: rtl/wprecomp_shifter.sv
module wprecomp_shifter
  import precomp_pkg::*;
#(
  parameter int TRACK_W       = 8,
  parameter int DEFAULT_SHIFT = 2,
  parameter int DEFAULT_START = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitStrobe,
  input  logic               bitIn,
  input  logic [TRACK_W-1:0] curTrack,
  input  logic               cfgShiftWe,
  input  logic [STEP_W-1:0]  cfgShiftData,
  input  logic               cfgTrackWe,
  input  logic [TRACK_W-1:0] cfgTrackData,
  output logic               wrPulse
);

  precomp_strobe_t strb;

  precomp_ctrl #(
    .TRACK_W      (TRACK_W),
    .DEFAULT_SHIFT(DEFAULT_SHIFT),
    .DEFAULT_START(DEFAULT_START)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitStrobe   (bitStrobe),
    .curTrack    (curTrack),
    .cfgShiftWe  (cfgShiftWe),
    .cfgShiftData(cfgShiftData),
    .cfgTrackWe  (cfgTrackWe),
    .cfgTrackData(cfgTrackData),
    .strb        (strb)
  );

  precomp_datapath i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .bitIn  (bitIn),
    .wrPulse(wrPulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !wrPulse); // R10

endmodule

// File: tb/test_wprecomp_shifter.sv
module test_wprecomp_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int CELL       = 8;
  localparam int NOM        = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       bitIn = 1'b0;
  logic [7:0] curTrack = 8'd5;
  logic       cfgShiftWe = 1'b0;
  logic [2:0] cfgShiftData = 3'd0;
  logic       cfgTrackWe = 1'b0;
  logic [7:0] cfgTrackData = 8'd0;
  logic       wrPulse;

  int errors = 0;
  int checks = 0;
  int edgeCount = 0;
  int doubleHigh = 0;
  logic prevPulse = 1'b0;
  int pulseTimes[$];

  wprecomp_shifter i_wprecomp_shifter (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitIn(bitIn),
    .curTrack(curTrack), .cfgShiftWe(cfgShiftWe), .cfgShiftData(cfgShiftData),
    .cfgTrackWe(cfgTrackWe), .cfgTrackData(cfgTrackData), .wrPulse(wrPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) edgeCount <= edgeCount + 1;

  always @(negedge clk) begin
    if (wrPulse) pulseTimes.push_back(edgeCount);
    if (wrPulse && prevPulse) doubleHigh++;
    prevPulse = wrPulse;
  end

  task automatic checkInt(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sendCell(input logic b, output int idx);
    @(negedge clk);
    bitIn = b;
    bitStrobe = 1'b1;
    idx = edgeCount + 1;
    @(negedge clk);
    bitStrobe = 1'b0;
    repeat (CELL - 2) @(negedge clk);
  endtask

  task automatic writeShift(input int v);
    @(negedge clk);
    cfgShiftData = 3'(v);
    cfgShiftWe = 1'b1;
    @(negedge clk);
    cfgShiftWe = 1'b0;
  endtask

  task automatic writeStart(input int v);
    @(negedge clk);
    cfgTrackData = 8'(v);
    cfgTrackWe = 1'b1;
    @(negedge clk);
    cfgTrackWe = 1'b0;
  endtask

  // Sends len cells (bit 0 first) plus two trailing zeros, then compares
  // every pulse time with the independently computed expectation.
  task automatic runPattern(input string tag, input logic [31:0] pat, input int len,
                            input int amt, input bit shiftOn);
    int idx[40];
    int expTimes[$];
    pulseTimes.delete();
    for (int i = 0; i < len + 2; i++) begin
      sendCell((i < len) ? pat[i] : 1'b0, idx[i]);
    end
    repeat (10) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (pat[i]) begin
        logic b2, a2;
        int tap;
        b2 = (i >= 2) ? pat[i-2] : 1'b0;
        a2 = (i + 2 < len) ? pat[i+2] : 1'b0;
        tap = NOM;
        if (shiftOn && b2 && !a2) tap = NOM + amt;
        if (shiftOn && !b2 && a2) tap = NOM - amt;
        expTimes.push_back(idx[i+2] + tap);
      end
    end
    checkInt(tag, "pulse count", pulseTimes.size(), expTimes.size());
    for (int k = 0; k < expTimes.size(); k++) begin
      if (k < pulseTimes.size())
        checkInt(tag, $sformatf("pulse %0d time", k), pulseTimes[k], expTimes[k]);
    end
  endtask

  task automatic testReset();
    int quiet = 1;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    if (wrPulse) quiet = 0;
    rstN = 1'b1;
    repeat (16) begin
      @(negedge clk);
      if (wrPulse) quiet = 0;
    end
    checkInt("R10", "pulse during/after reset", quiet, 1);
    curTrack = 8'd5;
    runPattern("R1", 32'h0000_0A45, 14, 2, 1'b1);
    curTrack = 8'd0;
    runPattern("R1", 32'h0000_0451, 12, 2, 1'b1);
  endtask

  task automatic testPatterns();
    curTrack = 8'd10;
    writeShift(3);
    runPattern("R2", 32'h0012_4A95, 24, 3, 1'b1);
    runPattern("R3", 32'h0089_1245, 24, 3, 1'b1);
    runPattern("R2", 32'h0000_5555, 16, 3, 1'b1);
    runPattern("R3", 32'h0009_2491, 20, 3, 1'b1);
  endtask

  task automatic testLatency();
    int idx[4];
    pulseTimes.delete();
    sendCell(1'b1, idx[0]);
    sendCell(1'b0, idx[1]);
    sendCell(1'b0, idx[2]);
    sendCell(1'b0, idx[3]);
    repeat (10) @(negedge clk);
    checkInt("R4", "isolated pulse count", pulseTimes.size(), 1);
    if (pulseTimes.size() > 0)
      checkInt("R4", "isolated pulse time", pulseTimes[0], idx[2] + NOM);
  endtask

  task automatic testSaturate();
    writeShift(6);
    runPattern("R5", 32'h0000_0A45, 14, 3, 1'b1);
    writeShift(7);
    runPattern("R5", 32'h0000_1151, 14, 3, 1'b1);
    writeShift(1);
    runPattern("R5", 32'h0000_0A45, 14, 1, 1'b1);
  endtask

  task automatic testTrackGate();
    writeShift(2);
    writeStart(40);
    curTrack = 8'd39;
    runPattern("R6", 32'h0000_0A45, 14, 2, 1'b0);
    curTrack = 8'd40;
    runPattern("R7", 32'h0000_0A45, 14, 2, 1'b1);
    curTrack = 8'd200;
    runPattern("R7", 32'h0000_1151, 14, 2, 1'b1);
    curTrack = 8'd0;
    runPattern("R6", 32'h0000_1151, 14, 2, 1'b0);
    writeStart(0);
  endtask

  task automatic testZero();
    curTrack = 8'd50;
    writeShift(0);
    runPattern("R8", 32'h0012_4A95, 24, 0, 1'b1);
    runPattern("R8", 32'h0000_0A45, 14, 0, 1'b1);
  endtask

  initial begin
    testReset();
    testPatterns();
    testLatency();
    testSaturate();
    testTrackGate();
    testZero();
    checkInt("R9", "clocks with pulse high twice in a row", doubleHigh, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule